// File: doc/BRIEF.md
# Fully Associative Translation Lookup

This block translates a 32-bit virtual address into a physical address by searching a small translation buffer in which every entry is compared at once. Each entry covers a pair of adjacent 4 KiB pages: one tag names the pair, and address bit 12 picks the even or the odd half. Each half has its own frame number, valid flag and dirty flag. An entry can be shared by all address spaces, or it can be private to one address-space identifier. It also carries an exclusive upper bound on the addresses it may translate.

A lookup is presented with the address, a write flag and the current address-space identifier. One clock later the block reports a status code and the physical address. The code says whether the access may go ahead, found no entry, found a half that is not valid, or found a clean half under a write. A simple indexed write port loads one entry per clock. The handler that owns the buffer uses this port to install mappings after a miss.

Top module: `tlb_lookup`

## Requirements
- R1: While reset is held and on the first cycles after it, `rs_valid` is 0. Every entry is cleared, with an end bound of 0, so every lookup made before any load reports miss.
- R2: An entry matches when its tag equals `lk_vaddr[31:13]`, the address is strictly below its end bound, and either its shared flag is set or its stored identifier equals `lk_asid`. Status codes are 0 hit, 1 miss, 2 invalid and 3 modified. A lookup that matches no entry reports 1.
- R3: Only virtual address bits 31..13 take part in the tag compare. A lookup one tag step above a loaded entry misses.
- R4: The end bound is exclusive. An address equal to the bound misses, and an address one below it matches.
- R5: Address bit 12 selects the half: 0 uses the even frame and flags, 1 uses the odd frame and flags.
- R6: On a hit, `rs_paddr` is the selected 20-bit frame in bits 31..12 with `lk_vaddr[11:0]` below it. On any other status, `rs_paddr` is 0.
- R7: A matching entry whose selected half is not valid reports invalid (2), for reads and for writes alike.
- R8: A matching valid half reports hit on a read. On a write it reports hit only if its dirty flag is set, and modified (3) otherwise.
- R9: When several entries match, the lowest-numbered one decides the status and the frame, even if its selected half is invalid. `rs_index` reports that entry's number.
- R10: A load made in the same cycle as a lookup does not affect that lookup. A lookup in the following cycle sees the new entry.
- R11: The result is registered. `rs_*` reflect the lookup presented one clock earlier, and `rs_valid` is 0 after a cycle with `lk_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| lk_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Load an entry this cycle |
| wr_index | input | 4 | Entry number to load |
| wr_tag | input | 19 | Page-pair tag (virtual address bits 31..13) |
| wr_asid | input | 8 | Owner identifier of the entry |
| wr_shared | input | 1 | Entry matches every identifier |
| wr_end | input | 32 | Exclusive upper address bound |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_valid_even | input | 1 | Even page valid |
| wr_dirty_even | input | 1 | Even page writable |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_valid_odd | input | 1 | Odd page valid |
| wr_dirty_odd | input | 1 | Odd page writable |
| rs_valid | output | 1 | Result below belongs to a lookup |
| rs_status | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modified |
| rs_paddr | output | 32 | Physical address (0 unless hit) |
| rs_index | output | 4 | Deciding entry number (0 on miss) |

## Verification
Every lookup result is due exactly one clock after the request is sampled. Each lookup task drives its request just after a falling edge, lets one rising edge pass, and reads all four result ports at the next falling edge. A load takes effect on the rising edge that samples it. For that reason, the same-cycle test drives a load and a lookup together and expects the old contents, then checks a second lookup one clock later against the new contents. The idle check looks one clock after a cycle with no request and expects `rs_valid` low.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  parameter int unsigned VA_W       = 32;
  parameter int unsigned ASID_W     = 8;
  parameter int unsigned PAGE_SHIFT = 12;
  localparam int unsigned TAG_LO    = PAGE_SHIFT + 1;
  localparam int unsigned TAG_W     = VA_W - TAG_LO;
  localparam int unsigned PFN_W     = VA_W - PAGE_SHIFT;

  typedef enum logic [1:0] {
    ST_HIT      = 2'd0,
    ST_MISS     = 2'd1,
    ST_INVALID  = 2'd2,
    ST_MODIFIED = 2'd3
  } tlb_status_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             valid;
    logic             dirty;
  } tlb_half_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              shared;
    logic [VA_W-1:0]   end_bound;
    tlb_half_t         even;
    tlb_half_t         odd;
  } tlb_entry_t;

  function automatic logic [TAG_W-1:0] va_tag(input logic [VA_W-1:0] va);
    return va[VA_W-1:TAG_LO];
  endfunction

  function automatic logic va_odd(input logic [VA_W-1:0] va);
    return va[PAGE_SHIFT];
  endfunction

  function automatic logic [VA_W-1:0] join_paddr(input logic [PFN_W-1:0] pfn,
                                                 input logic [VA_W-1:0]  va);
    return {pfn, va[PAGE_SHIFT-1:0]};
  endfunction

  function automatic tlb_status_e classify(input logic any_match,
                                           input logic half_valid,
                                           input logic half_dirty,
                                           input logic is_write);
    if (!any_match)                  return ST_MISS;
    else if (!half_valid)            return ST_INVALID;
    else if (is_write && !half_dirty) return ST_MODIFIED;
    else                             return ST_HIT;
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlbx_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_index,
  input  tlb_entry_t                      wr_entry,
  output tlb_entry_t [N_ENTRIES-1:0]      entries
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   entries[g] <= '0;
      else if (wr_en && wr_index == IDX_W'(g))      entries[g] <= wr_entry;
    end
  end
endmodule

// File: rtl/tlb_match_unit.sv
module tlb_match_unit
  import tlbx_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16
) (
  input  tlb_entry_t [N_ENTRIES-1:0] entries,
  input  logic [VA_W-1:0]            va,
  input  logic [ASID_W-1:0]          asid,
  output logic [N_ENTRIES-1:0]       match_vec
);
  logic [TAG_W-1:0] cmp_tag;
  assign cmp_tag = va_tag(va);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic owner_ok, tag_ok, range_ok;
    assign owner_ok     = entries[g].shared || (entries[g].asid == asid);
    assign tag_ok       = (entries[g].tag == cmp_tag);
    assign range_ok     = (va < entries[g].end_bound);
    assign match_vec[g] = owner_ok && tag_ok && range_ok;
  end
endmodule

// File: rtl/tlb_prio_select.sv
module tlb_prio_select #(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0] match_vec,
  output logic                 hit_any,
  output logic [IDX_W-1:0]     win_idx,
  output logic [N_ENTRIES-1:0] win_onehot
);
  always_comb begin
    win_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign hit_any    = |match_vec;
  assign win_onehot = hit_any ? (N_ENTRIES'(1) << win_idx) : '0;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlbx_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic                  lk_write,
  input  logic [ASID_W-1:0]     lk_asid,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_index,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [ASID_W-1:0]     wr_asid,
  input  logic                  wr_shared,
  input  logic [VA_W-1:0]       wr_end,
  input  logic [PFN_W-1:0]      wr_pfn_even,
  input  logic                  wr_valid_even,
  input  logic                  wr_dirty_even,
  input  logic [PFN_W-1:0]      wr_pfn_odd,
  input  logic                  wr_valid_odd,
  input  logic                  wr_dirty_odd,
  output logic                  rs_valid,
  output logic [1:0]            rs_status,
  output logic [VA_W-1:0]       rs_paddr,
  output logic [IDX_W-1:0]      rs_index
);
  tlb_entry_t                 wr_entry;
  tlb_entry_t [N_ENTRIES-1:0] entries;
  logic [N_ENTRIES-1:0]       match_vec;
  logic [N_ENTRIES-1:0]       win_onehot;
  logic                       hit_any;
  logic [IDX_W-1:0]           win_idx;
  tlb_entry_t                 sel_entry;
  tlb_half_t                  sel_half;
  tlb_status_e                st_next;
  logic [VA_W-1:0]            paddr_next;

  always_comb begin
    wr_entry.tag       = wr_tag;
    wr_entry.asid      = wr_asid;
    wr_entry.shared    = wr_shared;
    wr_entry.end_bound = wr_end;
    wr_entry.even      = '{pfn: wr_pfn_even, valid: wr_valid_even, dirty: wr_dirty_even};
    wr_entry.odd       = '{pfn: wr_pfn_odd,  valid: wr_valid_odd,  dirty: wr_dirty_odd};
  end

  tlb_entry_store #(.N_ENTRIES(N_ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_index (wr_index),
    .wr_entry (wr_entry),
    .entries  (entries)
  );

  tlb_match_unit #(.N_ENTRIES(N_ENTRIES)) u_match (
    .entries   (entries),
    .va        (lk_vaddr),
    .asid      (lk_asid),
    .match_vec (match_vec)
  );

  tlb_prio_select #(.N_ENTRIES(N_ENTRIES)) u_prio (
    .match_vec  (match_vec),
    .hit_any    (hit_any),
    .win_idx    (win_idx),
    .win_onehot (win_onehot)
  );

  assign sel_entry  = entries[win_idx];
  assign sel_half   = va_odd(lk_vaddr) ? sel_entry.odd : sel_entry.even;
  assign st_next    = classify(hit_any, sel_half.valid, sel_half.dirty, lk_write);
  assign paddr_next = (st_next == ST_HIT) ? join_paddr(sel_half.pfn, lk_vaddr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_status <= ST_MISS;
      rs_paddr  <= '0;
      rs_index  <= '0;
    end else begin
      rs_valid <= lk_valid;
      if (lk_valid) begin
        rs_status <= st_next;
        rs_paddr  <= paddr_next;
        rs_index  <= hit_any ? win_idx : '0;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_checker.sv
module tlb_lookup_checker
  import tlbx_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lk_valid,
  input logic [VA_W-1:0]      lk_vaddr,
  input logic                 lk_write,
  input logic                 rs_valid,
  input logic [1:0]           rs_status,
  input logic [VA_W-1:0]      rs_paddr,
  input logic [N_ENTRIES-1:0] match_vec,
  input logic [N_ENTRIES-1:0] win_onehot,
  input logic                 hit_any
);
  assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rs_valid);

  assert_nomatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !hit_any) |=> (rs_status == ST_MISS));

  assert_offset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_status == ST_HIT) |->
      (rs_paddr[PAGE_SHIFT-1:0] == $past(lk_vaddr[PAGE_SHIFT-1:0])));

  assert_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_status != ST_HIT) |-> (rs_paddr == '0));

  assert_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_status == ST_MODIFIED) |-> $past(lk_write));

  assert_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot) && ((win_onehot & ~match_vec) == '0));
endmodule

bind tlb_lookup tlb_lookup_checker #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_write   (lk_write),
  .rs_valid   (rs_valid),
  .rs_status  (rs_status),
  .rs_paddr   (rs_paddr),
  .match_vec  (match_vec),
  .win_onehot (win_onehot),
  .hit_any    (hit_any)
);

// File: tb/test_tlb_lookup.sv
module test_tlb_lookup;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_HIT = 2'd0, S_MISS = 2'd1, S_INV = 2'd2, S_MOD = 2'd3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_write = 0;
  logic [7:0]  lk_asid = '0;
  logic        wr_en = 0;
  logic [3:0]  wr_index = '0;
  logic [18:0] wr_tag = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_shared = 0;
  logic [31:0] wr_end = '0;
  logic [19:0] wr_pfn_even = '0, wr_pfn_odd = '0;
  logic        wr_valid_even = 0, wr_dirty_even = 0, wr_valid_odd = 0, wr_dirty_odd = 0;
  logic        rs_valid;
  logic [1:0]  rs_status;
  logic [31:0] rs_paddr;
  logic [3:0]  rs_index;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_lookup i_tlb_lookup (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_entry(input logic [3:0] idx, input logic [18:0] tag,
                           input logic [7:0] asid, input logic shared,
                           input logic [31:0] bound,
                           input logic [19:0] pe, input logic ve, input logic de,
                           input logic [19:0] po, input logic vo, input logic dodd);
    wr_index = idx; wr_tag = tag; wr_asid = asid; wr_shared = shared; wr_end = bound;
    wr_pfn_even = pe; wr_valid_even = ve; wr_dirty_even = de;
    wr_pfn_odd = po; wr_valid_odd = vo; wr_dirty_odd = dodd;
  endtask

  task automatic load(input logic [3:0] idx, input logic [18:0] tag,
                      input logic [7:0] asid, input logic shared,
                      input logic [31:0] bound,
                      input logic [19:0] pe, input logic ve, input logic de,
                      input logic [19:0] po, input logic vo, input logic dodd);
    @(negedge clk);
    set_entry(idx, tag, asid, shared, bound, pe, ve, de, po, vo, dodd);
    wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic wr,
                        input logic [7:0] asid, input logic [1:0] exp_st,
                        input logic [31:0] exp_pa, input logic [3:0] exp_idx);
    @(negedge clk);
    lk_vaddr = va; lk_write = wr; lk_asid = asid; lk_valid = 1;
    @(negedge clk);
    lk_valid = 0;
    check(req, "rs_valid", {31'b0, rs_valid}, 32'd1);
    check(req, "status", {30'b0, rs_status}, {30'b0, exp_st});
    check(req, "paddr", rs_paddr, exp_pa);
    if (exp_st != S_MISS) check(req, "index", {28'b0, rs_index}, {28'b0, exp_idx});
  endtask

  task automatic t_reset;
    check("R1", "rs_valid in reset", {31'b0, rs_valid}, 32'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", "rs_valid after reset", {31'b0, rs_valid}, 32'd0);
    lookup("R1", 32'h0000_1000, 0, 8'd0, S_MISS, 32'h0, 4'd0);
    lookup("R1", 32'h2468_A123, 0, 8'd5, S_MISS, 32'h0, 4'd0);
  endtask

  task automatic t_private;
    load(4'd3, 19'h12345, 8'd5, 0, 32'hFFFF_FFFF, 20'hABCDE, 1, 1, 20'h13579, 1, 0);
    lookup("R2 R5 R6 even", 32'h2468_A123, 0, 8'd5, S_HIT, 32'hABCD_E123, 4'd3);
    lookup("R5 odd",        32'h2468_B456, 0, 8'd5, S_HIT, 32'h1357_9456, 4'd3);
    lookup("R2 asid",       32'h2468_A123, 0, 8'd6, S_MISS, 32'h0, 4'd0);
    lookup("R8 clean wr",   32'h2468_B456, 1, 8'd5, S_MOD, 32'h0, 4'd3);
    lookup("R8 dirty wr",   32'h2468_A010, 1, 8'd5, S_HIT, 32'hABCD_E010, 4'd3);
    lookup("R3 next tag",   32'h2468_C000, 0, 8'd5, S_MISS, 32'h0, 4'd0);
  endtask

  task automatic t_shared_bound;
    load(4'd4, 19'h00010, 8'd9, 1, 32'h0002_1800, 20'h11111, 1, 1, 20'h22222, 0, 0);
    lookup("R2 shared",   32'h0002_0010, 0, 8'h77, S_HIT, 32'h1111_1010, 4'd4);
    lookup("R7 rd",       32'h0002_1010, 0, 8'h77, S_INV, 32'h0, 4'd4);
    lookup("R7 wr",       32'h0002_1010, 1, 8'h77, S_INV, 32'h0, 4'd4);
    lookup("R4 at bound", 32'h0002_1800, 0, 8'h77, S_MISS, 32'h0, 4'd0);
    lookup("R4 below",    32'h0002_17FF, 0, 8'h77, S_INV, 32'h0, 4'd4);
  endtask

  task automatic t_priority;
    load(4'd7, 19'h40000, 8'd2, 0, 32'hFFFF_FFFF, 20'hBBBBB, 1, 1, 20'h0, 0, 0);
    load(4'd1, 19'h40000, 8'd2, 0, 32'hFFFF_FFFF, 20'hAAAAA, 1, 1, 20'h0, 0, 0);
    lookup("R9 lowest", 32'h8000_0004, 0, 8'd2, S_HIT, 32'hAAAA_A004, 4'd1);
    load(4'd1, 19'h40000, 8'd2, 0, 32'hFFFF_FFFF, 20'hAAAAA, 0, 1, 20'h0, 0, 0);
    lookup("R9 invalid wins", 32'h8000_0004, 0, 8'd2, S_INV, 32'h0, 4'd1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    set_entry(4'd1, 19'h40000, 8'd2, 0, 32'hFFFF_FFFF, 20'hCCCCC, 1, 1, 20'h0, 0, 0);
    wr_en = 1;
    lk_vaddr = 32'h8000_0004; lk_write = 0; lk_asid = 8'd2; lk_valid = 1;
    @(negedge clk);
    wr_en = 0;
    check("R10 old contents", "status", {30'b0, rs_status}, {30'b0, S_INV});
    check("R11 one cycle", "rs_valid", {31'b0, rs_valid}, 32'd1);
    @(negedge clk);
    lk_valid = 0;
    check("R10 new contents", "status", {30'b0, rs_status}, {30'b0, S_HIT});
    check("R10 new contents", "paddr", rs_paddr, 32'hCCCC_C004);
    @(negedge clk);
    check("R11 idle", "rs_valid", {31'b0, rs_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_private();
    t_shared_bound();
    t_priority();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++;
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule